// File: doc/BRIEF.md
# Dead-Band Charge Accumulator

This block integrates signed current-sense samples into three coulomb counters: one for charge, one for discharge and one signed net total. Each accepted sample is first corrected by subtracting two offsets: one from an automatic calibration and one programmed by the user to cancel board-level error. The magnitude of the corrected value is then compared with a dead-band threshold. Anything smaller than the threshold is dropped, so a small residual offset cannot build into a capacity error over hours of idle time. A threshold of zero turns the dead-band off.

Samples enter through a valid/ready channel. `s_ready` is low only while `clr` is high. A sample moves only on a clock edge where both `s_valid` and `s_ready` are high, and the offsets and threshold are taken from that same edge. The producer must hold `s_valid` and its data until that edge. There is no back-pressure from the outputs. The counters are plain registered outputs, and `acc_upd` pulses once for every sample that reaches them.

Top module: `charge_deadband_acc`

## Requirements
- R1: The corrected value is `s_sample - int_ofs - ext_ofs`, computed in full signed precision. A positive corrected value that passes the dead-band is added to `chg_acc`.
- R2: A negative corrected value that passes the dead-band adds its magnitude to `dsg_acc`. No accepted sample changes both `chg_acc` and `dsg_acc`.
- R3: `net_acc` is the signed sum of every corrected value that passes the dead-band.
- R4: With a non-zero `db_thresh`, a corrected value whose magnitude is strictly below `db_thresh` leaves all three accumulators unchanged. `db_thresh` has the same LSB as the sample, 4.9 µV.
- R5: A corrected magnitude exactly equal to a non-zero `db_thresh` is accumulated.
- R6: With `db_thresh` equal to 0, every non-zero corrected value is accumulated, and a corrected value of zero changes nothing.
- R7: `chg_acc` and `dsg_acc` are unsigned. Each holds at 2^ACC_W-1 instead of wrapping.
- R8: `net_acc` is two's complement. It holds at its most positive or most negative value instead of wrapping.
- R9: `range_err` pulses together with `acc_upd` when the raw sample magnitude exceeds RANGE_LIM (20408 LSB, about 100 mV). Such a sample is still processed normally.
- R10: While `clr` is high, `s_ready` is low. After the edge on which `clr` is high, all accumulators read 0. A sample accepted on the edge just before that is discarded and does not raise `acc_upd`.
- R11: Reset leaves all accumulators at 0 and `acc_upd` low. A sample accepted on clock edge k is reflected in the accumulators, with `acc_upd` high, after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of accumulators and of the in-flight sample |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (low during clear) |
| s_sample | input | SAMPLE_W | Signed sense-voltage sample, 4.9 µV per LSB |
| int_ofs | input | OFS_W | Signed auto-calibrated offset |
| ext_ofs | input | OFS_W | Signed user-programmed board offset |
| db_thresh | input | THR_W | Unsigned dead-band threshold, 0 disables |
| chg_acc | output | ACC_W | Saturating charge total |
| dsg_acc | output | ACC_W | Saturating discharge total |
| net_acc | output | ACC_W | Saturating signed net total |
| acc_upd | output | 1 | Pulse: a sample reached the accumulators |
| range_err | output | 1 | Pulse with acc_upd: raw sample out of range |

## Verification
The assertions rely on three things about the inputs. Reset is held from time zero. The producer never counts on a transfer while `clr` is high, since `s_ready` is low then. The accumulators move only as a result of accepted samples or a clear. The stimulus raises `clr` only when no sample is waiting to be offered, except in one deliberate case that places a sample in flight just before a clear. Offsets and the threshold change only together with a new sample. Saturation runs use full-scale samples on a narrowed accumulator width, so that both limits are reached within a few dozen transfers.

// File: rtl/dbca_pkg.sv
`timescale 1ns/1ps
package dbca_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_CHG  = 2'd1,
    DIR_DSG  = 2'd2
  } dir_e;
endpackage

// File: rtl/dbca_correct.sv
`timescale 1ns/1ps
// Offset subtraction and raw range check.
module dbca_correct #(
  parameter int SAMPLE_W  = 16,
  parameter int OFS_W     = 16,
  parameter int CW        = 18,
  parameter int RANGE_LIM = 20408
) (
  input  logic signed [SAMPLE_W-1:0] raw,
  input  logic signed [OFS_W-1:0]    iofs,
  input  logic signed [OFS_W-1:0]    eofs,
  output logic signed [CW-1:0]       corr,
  output logic                       oor
);
  localparam int XW = SAMPLE_W + 1;
  logic signed [XW-1:0] raw_x;
  logic        [XW-1:0] raw_mag;

  always_comb begin
    corr    = CW'(raw) - CW'(iofs) - CW'(eofs);
    raw_x   = XW'(raw);
    raw_mag = raw_x[XW-1] ? -raw_x : raw_x;
    oor     = raw_mag > XW'(RANGE_LIM);
  end
endmodule

// File: rtl/dbca_deadband.sv
`timescale 1ns/1ps
// Magnitude dead-band classifier.
module dbca_deadband
  import dbca_pkg::*;
#(
  parameter int CW    = 18,
  parameter int THR_W = 15
) (
  input  logic signed [CW-1:0] corr,
  input  logic [THR_W-1:0]     thr,
  output dir_e                 cls,
  output logic [CW-1:0]        mag
);
  localparam int CMP_W = ((CW > THR_W) ? CW : THR_W) + 1;
  logic [CMP_W-1:0] mag_x;
  logic [CMP_W-1:0] thr_x;
  logic             hit;

  always_comb begin
    mag   = corr[CW-1] ? -corr : corr;
    mag_x = CMP_W'(mag);
    thr_x = CMP_W'(thr);
    if (thr == '0) hit = (corr != '0);
    else           hit = (mag_x >= thr_x);
    if (!hit)              cls = DIR_NONE;
    else if (corr[CW-1])   cls = DIR_DSG;
    else                   cls = DIR_CHG;
  end
endmodule

// File: rtl/dbca_sat_uacc.sv
`timescale 1ns/1ps
// Unsigned accumulator that holds at all-ones.
module dbca_sat_uacc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [ACC_W-1:0] add,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W:0] sum;
  assign sum = {1'b0, acc} + {1'b0, add};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (clr)        acc <= '0;
    else if (en) begin
      if (sum[ACC_W])    acc <= '1;
      else               acc <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/dbca_sat_sacc.sv
`timescale 1ns/1ps
// Signed accumulator that holds at its extremes.
module dbca_sat_sacc #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] delta,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};
  logic signed [ACC_W:0] sum;
  logic                  ovf;

  assign sum = {acc[ACC_W-1], acc} + {delta[ACC_W-1], delta};
  assign ovf = sum[ACC_W] ^ sum[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (clr)      acc <= '0;
    else if (en) begin
      if (ovf)         acc <= sum[ACC_W] ? NEG_LIM : POS_LIM;
      else             acc <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/charge_deadband_acc.sv
`timescale 1ns/1ps
module charge_deadband_acc
  import dbca_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int OFS_W     = 16,
  parameter int THR_W     = 15,
  parameter int ACC_W     = 32,
  parameter int RANGE_LIM = 20408
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_sample,
  input  logic signed [OFS_W-1:0]    int_ofs,
  input  logic signed [OFS_W-1:0]    ext_ofs,
  input  logic [THR_W-1:0]           db_thresh,
  output logic [ACC_W-1:0]           chg_acc,
  output logic [ACC_W-1:0]           dsg_acc,
  output logic signed [ACC_W-1:0]    net_acc,
  output logic                       acc_upd,
  output logic                       range_err
);
  localparam int CW = ((SAMPLE_W > OFS_W) ? SAMPLE_W : OFS_W) + 2;
  localparam int NDIR = 2;

  logic                 take;
  logic signed [CW-1:0] corr_c;
  logic                 oor_c;
  dir_e                 cls_c;
  logic [CW-1:0]        mag_c;

  // stage register between classification and accumulation
  logic                 st_vld;
  dir_e                 st_cls;
  logic [CW-1:0]        st_mag;
  logic signed [CW-1:0] st_corr;
  logic                 st_oor;

  assign s_ready = ~clr;
  assign take    = s_valid & s_ready;

  dbca_correct #(
    .SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W), .CW(CW), .RANGE_LIM(RANGE_LIM)
  ) u_correct (
    .raw(s_sample), .iofs(int_ofs), .eofs(ext_ofs), .corr(corr_c), .oor(oor_c)
  );

  dbca_deadband #(.CW(CW), .THR_W(THR_W)) u_deadband (
    .corr(corr_c), .thr(db_thresh), .cls(cls_c), .mag(mag_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld  <= 1'b0;
      st_cls  <= DIR_NONE;
      st_mag  <= '0;
      st_corr <= '0;
      st_oor  <= 1'b0;
    end else if (clr) begin
      st_vld  <= 1'b0;
    end else begin
      st_vld <= take;
      if (take) begin
        st_cls  <= cls_c;
        st_mag  <= mag_c;
        st_corr <= corr_c;
        st_oor  <= oor_c;
      end
    end
  end

  // directional totals: index 0 charge, index 1 discharge
  logic [NDIR-1:0]  dir_en;
  logic [ACC_W-1:0] dir_acc [NDIR];
  logic [ACC_W-1:0] dir_add;

  assign dir_add   = ACC_W'(st_mag);
  assign dir_en[0] = st_vld & (st_cls == DIR_CHG);
  assign dir_en[1] = st_vld & (st_cls == DIR_DSG);

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      dbca_sat_uacc #(.ACC_W(ACC_W)) u_uacc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(dir_en[g]),
        .add(dir_add), .acc(dir_acc[g])
      );
    end
  endgenerate

  assign chg_acc = dir_acc[0];
  assign dsg_acc = dir_acc[1];

  logic signed [ACC_W-1:0] net_delta;
  assign net_delta = ACC_W'(st_corr);

  dbca_sat_sacc #(.ACC_W(ACC_W)) u_net (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(st_vld & (st_cls != DIR_NONE)),
    .delta(net_delta), .acc(net_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_upd   <= 1'b0;
      range_err <= 1'b0;
    end else begin
      acc_upd   <= st_vld & ~clr;
      range_err <= st_vld & st_oor & ~clr;
    end
  end
endmodule

// File: rtl/charge_deadband_acc_chk.sv
`timescale 1ns/1ps
module charge_deadband_acc_chk #(
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    s_valid,
  input logic                    s_ready,
  input logic [ACC_W-1:0]        chg_acc,
  input logic [ACC_W-1:0]        dsg_acc,
  input logic signed [ACC_W-1:0] net_acc,
  input logic                    acc_upd,
  input logic                    range_err
);
  assert_ready_low_in_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !s_ready);

  assert_cleared_totals_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (chg_acc == '0 && dsg_acc == '0 && net_acc == '0 && !acc_upd));

  assert_chg_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (chg_acc >= $past(chg_acc)));

  assert_dsg_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (dsg_acc >= $past(dsg_acc)));

  assert_hold_without_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !acc_upd) |-> ($stable(chg_acc) && $stable(dsg_acc) && $stable(net_acc)));

  assert_one_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> !($changed(chg_acc) && $changed(dsg_acc)));

  assert_update_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_upd |-> $past(s_valid && s_ready, 2));

  assert_range_with_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> acc_upd);
endmodule

bind charge_deadband_acc charge_deadband_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .s_valid(s_valid), .s_ready(s_ready),
  .chg_acc(chg_acc), .dsg_acc(dsg_acc), .net_acc(net_acc),
  .acc_upd(acc_upd), .range_err(range_err)
);

// File: tb/charge_deadband_acc_test.sv
`timescale 1ns/1ps
module charge_deadband_acc_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int OW = 16;
  localparam int TW = 15;
  localparam int AW = 20;
  localparam int LIM = 20408;
  localparam longint CMAX = (longint'(1) << AW) - 1;
  localparam longint NMAX = (longint'(1) << (AW - 1)) - 1;
  localparam longint NMIN = -(longint'(1) << (AW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [SW-1:0] s_sample = '0;
  logic signed [OW-1:0] int_ofs = '0;
  logic signed [OW-1:0] ext_ofs = '0;
  logic [TW-1:0] db_thresh = '0;
  logic [AW-1:0] chg_acc;
  logic [AW-1:0] dsg_acc;
  logic signed [AW-1:0] net_acc;
  logic acc_upd;
  logic range_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_deadband_acc #(
    .SAMPLE_W(SW), .OFS_W(OW), .THR_W(TW), .ACC_W(AW), .RANGE_LIM(LIM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .int_ofs(int_ofs), .ext_ofs(ext_ofs), .db_thresh(db_thresh),
    .chg_acc(chg_acc), .dsg_acc(dsg_acc), .net_acc(net_acc),
    .acc_upd(acc_upd), .range_err(range_err)
  );

  typedef struct {
    longint c;
    longint d;
    longint n;
    bit     oor;
    string  tag;
  } exp_t;

  exp_t   sbq[$];
  int     n_chk = 0;
  int     n_bad = 0;
  longint mc = 0, md = 0, mn = 0;
  bit     done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // driver: present one sample, model its effect, push expectation
  task automatic send(input int raw, input int io, input int eo, input int th,
                      input string tag, input bit push);
    longint corr, mag;
    bit hit;
    exp_t e;
    s_sample  = SW'(raw);
    int_ofs   = OW'(io);
    ext_ofs   = OW'(eo);
    db_thresh = TW'(th);
    s_valid   = 1'b1;
    corr = longint'(raw) - io - eo;
    mag  = (corr < 0) ? -corr : corr;
    hit  = (th == 0) ? (corr != 0) : (mag >= th);
    if (push) begin
      if (hit) begin
        if (corr > 0) mc = (mc + corr > CMAX) ? CMAX : mc + corr;
        else          md = (md + mag > CMAX) ? CMAX : md + mag;
        mn = mn + corr;
        if (mn > NMAX) mn = NMAX;
        if (mn < NMIN) mn = NMIN;
      end
      e.c = mc; e.d = md; e.n = mn;
      e.oor = (raw > LIM) || (raw < -LIM);
      e.tag = tag;
      sbq.push_back(e);
    end
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #1 check(s_ready == 1'b0, "R10", $sformatf("s_ready=%0b exp 0 during clear", s_ready));
    @(posedge clk);
    #1 clr = 1'b0;
    mc = 0; md = 0; mn = 0;
    @(negedge clk);
    check(chg_acc == 0 && dsg_acc == 0 && net_acc == 0, "R10",
          $sformatf("after clear c=%0d d=%0d n=%0d exp 0/0/0", chg_acc, dsg_acc, net_acc));
  endtask

  // monitor: compare against scoreboard on every update
  always @(negedge clk) begin
    if (rst_n && acc_upd && !done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R11", "update with no expected item, exp none");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(longint'(chg_acc) == e.c && longint'(dsg_acc) == e.d &&
              longint'(net_acc) == e.n && range_err == e.oor, e.tag,
              $sformatf("c=%0d d=%0d n=%0d oor=%0b exp c=%0d d=%0d n=%0d oor=%0b",
                        chg_acc, dsg_acc, net_acc, range_err, e.c, e.d, e.n, e.oor));
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired, exp completion");
    finish_run();
  end

  initial begin
    idle(3);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(chg_acc == 0 && dsg_acc == 0 && net_acc == 0 && !acc_upd && s_ready, "R11",
          $sformatf("reset c=%0d d=%0d n=%0d upd=%0b rdy=%0b exp 0/0/0/0/1",
                    chg_acc, dsg_acc, net_acc, acc_upd, s_ready));
    // R11 latency: not visible after the acceptance edge
    send(500, 20, 30, 100, "R1", 1'b1);
    @(negedge clk);
    check(acc_upd == 1'b0 && chg_acc == 0, "R11",
          $sformatf("one edge after accept upd=%0b c=%0d exp 0/0", acc_upd, chg_acc));
    idle(3);
    send(-800, 10, -5, 100, "R2", 1'b1);
    send(50, 0, 0, 100, "R4", 1'b1);
    send(-99, 0, 0, 100, "R4", 1'b1);
    send(130, 40, 0, 100, "R4", 1'b1);
    send(100, 0, 0, 100, "R5", 1'b1);
    send(-100, 0, 0, 100, "R5", 1'b1);
    send(103, 2, 1, 100, "R5", 1'b1);
    send(1, 0, 0, 0, "R6", 1'b1);
    send(0, 0, 0, 0, "R6", 1'b1);
    send(-1, 0, 0, 0, "R6", 1'b1);
    send(5, 3, 2, 0, "R6", 1'b1);
    send(21000, 0, 0, 0, "R9", 1'b1);
    send(-20408, 0, 0, 0, "R9", 1'b1);
    send(-20409, 100, 0, 0, "R9", 1'b1);
    send(300, -200, -100, 50, "R3", 1'b1);
    send(-32768, 32767, 32767, 0, "R3", 1'b1);
    idle(4);
    do_clear();
    // in-flight sample is discarded by a clear on the next edge
    send(700, 0, 0, 0, "R10", 1'b0);
    clr = 1'b1;
    @(posedge clk);
    #1 clr = 1'b0;
    @(negedge clk);
    check(chg_acc == 0 && !acc_upd, "R10",
          $sformatf("flushed c=%0d upd=%0b exp 0/0", chg_acc, acc_upd));
    idle(3);
    for (int i = 0; i < 60; i++) send(20000, 0, 0, 0, "R7 R8 positive", 1'b1);
    idle(4);
    check(longint'(chg_acc) == CMAX && longint'(net_acc) == NMAX, "R7",
          $sformatf("c=%0d n=%0d exp %0d/%0d", chg_acc, net_acc, CMAX, NMAX));
    do_clear();
    for (int i = 0; i < 60; i++) send(-20000, 0, 0, 0, "R7 R8 negative", 1'b1);
    idle(4);
    check(longint'(dsg_acc) == CMAX && longint'(net_acc) == NMIN, "R8",
          $sformatf("d=%0d n=%0d exp %0d/%0d", dsg_acc, net_acc, CMAX, NMIN));
    check(sbq.size() == 0, "R11", $sformatf("pending=%0d exp 0", sbq.size()));
    finish_run();
  end
endmodule